// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Mode

This block is the watchdog of a small microcontroller core. A 15-bit synchronous counter advances on a clock-enable tick taken from one of two sources: a slow on-chip RC oscillator tick or the instruction-cycle tick. A static option can also switch the watchdog off. When the selected period passes without a valid clear, the block raises a one-cycle reset request. If the core is halted at that moment, it raises a wake-up request instead. In both cases it sets a sticky timeout flag.

Software restarts the count with clear instructions, which instruction decode turns into single-cycle strobes. In single-clear mode one dedicated strobe is enough. In paired-clear mode two different clear strobes must both have been seen, in either order, before the counter restarts. The configuration (source, clear mode and period) is captured while system reset is asserted and stays frozen after that.

Top module: `wdt_dual_clear`

## Requirements
- R1: `cfg_src_i` selects the tick source: 2'b01 counts `rc_tick_i`, 2'b10 counts `insn_tick_i`, and 2'b00 or 2'b11 turns the watchdog off. The tick that is not selected has no effect on the count.
- R2: With `cfg_period_i` = p, a timeout happens on the 2^(12+p)-th selected tick after reset or after the last successful clear.
- R3: In single-clear mode (`cfg_dual_i` = 0), a `clr_single_i` strobe restarts the count. `clr_first_i` and `clr_second_i` are ignored in this mode.
- R4: In paired-clear mode (`cfg_dual_i` = 1), the count restarts in the cycle in which both `clr_first_i` and `clr_second_i` have been seen since the last restart, in either order. `clr_single_i` is ignored in this mode.
- R5: In paired-clear mode, repeating the same clear strobe before the other one arrives has no effect.
- R6: On a timeout with `halt_i` low, `wdt_rst_o` is high for exactly one clock, in the cycle after the terminal tick.
- R7: On a timeout with `halt_i` high, `wake_o` is high for one clock and `wdt_rst_o` stays low.
- R8: `wdt_to_o` is set by every timeout and stays set until a successful clear, which drops it in the next cycle.
- R9: When the watchdog is off, the counter and the pending clear flags are held at zero and no output is ever asserted.
- R10: The configuration inputs are sampled only while `rst_n` is low. Changes made after reset has been released have no effect.
- R11: A successful clear in the same cycle as a tick wins: the count goes to zero and the tick is not counted.
- R12: During reset and right after it, `wdt_rst_o`, `wake_o` and `wdt_to_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset; configuration is captured while it is low |
| rc_tick_i | input | 1 | One-cycle enable from the RC oscillator domain |
| insn_tick_i | input | 1 | One-cycle enable per instruction cycle |
| cfg_src_i | input | 2 | Tick source: 01 RC, 10 instruction, 00/11 off |
| cfg_dual_i | input | 1 | 1 = paired-clear mode, 0 = single-clear mode |
| cfg_period_i | input | 2 | Period select p, where the period is 2^(12+p) ticks |
| clr_single_i | input | 1 | Clear strobe used in single-clear mode |
| clr_first_i | input | 1 | First clear strobe of the pair |
| clr_second_i | input | 1 | Second clear strobe of the pair |
| halt_i | input | 1 | Core is halted |
| wdt_rst_o | output | 1 | One-cycle reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| wdt_to_o | output | 1 | Sticky timeout flag |

## Verification
The checker takes for granted that `rst_n` is synchronous, is held for at least one clock edge, and is the only time the configuration pins can be captured. It also assumes that the tick and clear inputs are plain single-cycle enables sampled on `clk`. The stimulus changes every input on the falling edge. It only moves the configuration pins after reset is released, and it does so on purpose, to show that those changes are ignored. Clear strobes are applied either alone or together with a tick, so that the precedence of a clear over a tick is exercised deliberately.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_CNT_W   = 15;
    localparam int WDT_BASE_EXP = 12;
    localparam int WDT_PSEL_W  = 2;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_RC   = 2'b01,
        SRC_INSN = 2'b10,
        SRC_OFFX = 2'b11
    } wdt_src_e;

    typedef struct packed {
        wdt_src_e                src;
        logic                    dual;
        logic [WDT_PSEL_W-1:0]   period;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_hold.sv
module wdt_cfg_hold
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_cfg_t cfg_i,
    output wdt_cfg_t cfg_q
);
    wdt_cfg_t cfg_d;

    // Transparent capture while reset is held, frozen afterwards.
    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d = cfg_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    output logic clr_ok
);
    typedef struct packed {
        logic seen_first;
        logic seen_second;
    } pend_t;

    pend_t pend_d, pend_q;
    logic  got_first, got_second;

    always_comb begin
        pend_d     = pend_q;
        clr_ok     = 1'b0;
        got_first  = pend_q.seen_first  | clr_first;
        got_second = pend_q.seen_second | clr_second;
        if (!enable) begin
            pend_d = '0;
        end else if (dual) begin
            clr_ok = got_first & got_second;
            if (clr_ok) begin
                pend_d = '0;
            end else begin
                pend_d.seen_first  = got_first;
                pend_d.seen_second = got_second;
            end
        end else begin
            clr_ok = clr_single;
            pend_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W    = 15,
    parameter int BASE_EXP = 12,
    parameter int PSEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              clear,
    input  logic [PSEL_W-1:0] period,
    output logic              to_evt
);
    localparam int NSEL = 1 << PSEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [NSEL-1:0] full;
    logic            term;

    // One terminal-count detector per selectable period.
    for (genvar p = 0; p < NSEL; p++) begin : g_term
        assign full[p] = &st_q.cnt[BASE_EXP+p-1:0];
    end

    assign term = full[period];

    always_comb begin
        st_d   = st_q;
        to_evt = 1'b0;
        if (!enable || clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (term) begin
                to_evt   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
    import wdt_pkg::*;
#(
    parameter int CNT_W    = WDT_CNT_W,
    parameter int BASE_EXP = WDT_BASE_EXP,
    parameter int PSEL_W   = WDT_PSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_tick_i,
    input  logic              insn_tick_i,
    input  logic [1:0]        cfg_src_i,
    input  logic              cfg_dual_i,
    input  logic [PSEL_W-1:0] cfg_period_i,
    input  logic              clr_single_i,
    input  logic              clr_first_i,
    input  logic              clr_second_i,
    input  logic              halt_i,
    output logic              wdt_rst_o,
    output logic              wake_o,
    output logic              wdt_to_o
);
    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic to_flag;
    } out_st_t;

    wdt_cfg_t cfg_in, cfg_q;
    logic     enable, tick, clr_ok, to_evt;
    out_st_t  out_d, out_q;

    assign cfg_in.src    = wdt_src_e'(cfg_src_i);
    assign cfg_in.dual   = cfg_dual_i;
    assign cfg_in.period = cfg_period_i;

    wdt_cfg_hold u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg_in),
        .cfg_q (cfg_q)
    );

    always_comb begin
        unique case (cfg_q.src)
            SRC_RC:   begin enable = 1'b1; tick = rc_tick_i;   end
            SRC_INSN: begin enable = 1'b1; tick = insn_tick_i; end
            default:  begin enable = 1'b0; tick = 1'b0;        end
        endcase
    end

    wdt_clear_ctrl u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .dual       (cfg_q.dual),
        .clr_single (clr_single_i),
        .clr_first  (clr_first_i),
        .clr_second (clr_second_i),
        .clr_ok     (clr_ok)
    );

    wdt_counter #(
        .CNT_W    (CNT_W),
        .BASE_EXP (BASE_EXP),
        .PSEL_W   (PSEL_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (tick),
        .clear  (clr_ok),
        .period (cfg_q.period),
        .to_evt (to_evt)
    );

    always_comb begin
        out_d = out_q;
        if (!enable) begin
            out_d = '0;
        end else begin
            out_d.rst_req  = to_evt & ~halt_i;
            out_d.wake_req = to_evt &  halt_i;
            if (clr_ok) begin
                out_d.to_flag = 1'b0;
            end else if (to_evt) begin
                out_d.to_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wdt_rst_o = out_q.rst_req;
    assign wake_o    = out_q.wake_req;
    assign wdt_to_o  = out_q.to_flag;
endmodule

// File: rtl/wdt_dual_clear_chk.sv
module wdt_dual_clear_chk
    import wdt_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     halt_i,
    input logic     wdt_rst_o,
    input logic     wake_o,
    input logic     wdt_to_o,
    input wdt_cfg_t cfg_q,
    input logic     clr_ok
);
    logic src_off;
    assign src_off = (cfg_q.src != SRC_RC) && (cfg_q.src != SRC_INSN);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o); // R6
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R7
    AST_RST_NOT_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> !$past(halt_i)); // R7
    AST_NO_DOUBLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_o && wake_o)); // R7
    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_o || wake_o) |-> wdt_to_o); // R8
    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> !wdt_to_o); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        src_off |-> (!wdt_rst_o && !wake_o && !wdt_to_o)); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q)); // R10
endmodule

bind wdt_dual_clear wdt_dual_clear_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (halt_i),
    .wdt_rst_o (wdt_rst_o),
    .wake_o    (wake_o),
    .wdt_to_o  (wdt_to_o),
    .cfg_q     (cfg_q),
    .clr_ok    (clr_ok)
);

// File: tb/tb_wdt_dual_clear.sv
module tb_wdt_dual_clear;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rc_tick_i = 1'b0, insn_tick_i = 1'b0;
    logic [1:0] cfg_src_i = 2'b00;
    logic       cfg_dual_i = 1'b0;
    logic [1:0] cfg_period_i = 2'b00;
    logic       clr_single_i = 1'b0, clr_first_i = 1'b0, clr_second_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       wdt_rst_o, wake_o, wdt_to_o;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    wdt_dual_clear dut (
        .clk(clk), .rst_n(rst_n), .rc_tick_i(rc_tick_i), .insn_tick_i(insn_tick_i),
        .cfg_src_i(cfg_src_i), .cfg_dual_i(cfg_dual_i), .cfg_period_i(cfg_period_i),
        .clr_single_i(clr_single_i), .clr_first_i(clr_first_i), .clr_second_i(clr_second_i),
        .halt_i(halt_i), .wdt_rst_o(wdt_rst_o), .wake_o(wake_o), .wdt_to_o(wdt_to_o)
    );

    // Vector fields: [7:6] src, [5] dual, [4:3] period, [2] halt, [1] expect reset, [0] expect wake
    localparam logic [7:0] VEC [6] = '{
        {2'b01, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0},
        {2'b01, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0},
        {2'b00, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {2'b01, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] src, input logic dual, input logic [1:0] per);
        @(negedge clk);
        rst_n = 1'b0; rc_tick_i = 1'b0; insn_tick_i = 1'b0; halt_i = 1'b0;
        clr_single_i = 1'b0; clr_first_i = 1'b0; clr_second_i = 1'b0;
        cfg_src_i = src; cfg_dual_i = dual; cfg_period_i = per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Counts ticks until the first request; returns 0 when none is seen.
    task automatic run_until(input int maxn, output int n_rst, output int n_wake);
        n_rst = 0; n_wake = 0;
        for (int k = 1; k <= maxn; k++) begin
            @(negedge clk);
            if (wdt_rst_o) n_rst = k;
            if (wake_o) n_wake = k;
            if (wdt_rst_o || wake_o) break;
        end
    endtask

    task automatic strobe(input logic s, input logic f, input logic c);
        clr_single_i = s; clr_first_i = f; clr_second_i = c;
        @(negedge clk);
        clr_single_i = 1'b0; clr_first_i = 1'b0; clr_second_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int nr, nw, expn;
        // R12: reset state
        do_reset(2'b01, 1'b0, 2'd0);
        check(!wdt_rst_o && !wake_o && !wdt_to_o, "R12 reset outputs", {wdt_rst_o, wake_o, wdt_to_o}, 0);

        // Table walk: R1/R2/R6/R7/R8/R9
        foreach (VEC[i]) begin
            do_reset(VEC[i][7:6], VEC[i][5], VEC[i][4:3]);
            halt_i = VEC[i][2];
            rc_tick_i   = (VEC[i][7:6] != 2'b10);
            insn_tick_i = (VEC[i][7:6] != 2'b01);
            expn = 1 << (12 + int'(VEC[i][4:3]));
            run_until(VEC[i][1] || VEC[i][0] ? expn + 4 : 5000, nr, nw);
            if (VEC[i][1]) begin
                check(nr == expn, "R2 period in ticks", nr, expn);
                check(nw == 0, "R6 no wake when running", nw, 0);
            end else if (VEC[i][0]) begin
                check(nw == expn, "R7 wake timing", nw, expn);
                check(nr == 0, "R7 no reset when halted", nr, 0);
            end else begin
                check(nr == 0 && nw == 0 && !wdt_to_o, "R9 disabled quiet", nr + nw, 0);
            end
            if (VEC[i][1] || VEC[i][0]) begin
                @(negedge clk);
                check(!wdt_rst_o && !wake_o, "R6 R7 single-cycle pulse", wdt_rst_o + wake_o, 0);
                check(wdt_to_o, "R8 sticky flag", wdt_to_o, 1);
            end
            rc_tick_i = 1'b0; insn_tick_i = 1'b0; halt_i = 1'b0;
        end

        // R3/R11: single clear together with a tick
        do_reset(2'b01, 1'b0, 2'd0);
        rc_tick_i = 1'b1;
        repeat (4000) @(negedge clk);
        strobe(1'b1, 1'b0, 1'b0);
        run_until(5000, nr, nw);
        check(nr == 4096, "R3 R11 single clear restarts", nr, 4096);
        rc_tick_i = 1'b0;
        strobe(1'b0, 1'b1, 1'b1);
        check(wdt_to_o, "R3 pair strobes ignored in single mode", wdt_to_o, 1);
        strobe(1'b1, 1'b0, 1'b0);
        check(!wdt_to_o, "R8 clear drops flag", wdt_to_o, 0);

        // R4/R5: paired clear
        do_reset(2'b01, 1'b1, 2'd0);
        rc_tick_i = 1'b1;
        repeat (4000) @(negedge clk);
        rc_tick_i = 1'b0;
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        rc_tick_i = 1'b1;
        run_until(200, nr, nw);
        check(nr == 96, "R5 R4 repeated first and single do not clear", nr, 96);
        rc_tick_i = 1'b0;
        strobe(1'b0, 1'b0, 1'b1);
        check(!wdt_to_o, "R4 second completes pending first", wdt_to_o, 0);
        rc_tick_i = 1'b1;
        run_until(5000, nr, nw);
        check(nr == 4096, "R4 full period after paired clear", nr, 4096);
        rc_tick_i = 1'b0;
        strobe(1'b0, 1'b0, 1'b1);
        check(wdt_to_o, "R4 second alone not enough", wdt_to_o, 1);
        strobe(1'b0, 1'b0, 1'b1);
        check(wdt_to_o, "R5 repeated second ignored", wdt_to_o, 1);
        strobe(1'b0, 1'b1, 1'b0);
        check(!wdt_to_o, "R4 reverse order clears", wdt_to_o, 0);

        // R1/R10: unselected tick ignored, config frozen after reset
        do_reset(2'b01, 1'b0, 2'd0);
        cfg_src_i = 2'b10; cfg_period_i = 2'd3; cfg_dual_i = 1'b1;
        insn_tick_i = 1'b1;
        run_until(4200, nr, nw);
        check(nr == 0 && nw == 0, "R1 unselected tick ignored", nr + nw, 0);
        insn_tick_i = 1'b0; rc_tick_i = 1'b1;
        run_until(5000, nr, nw);
        check(nr == 4096, "R10 config changes after reset ignored", nr, 4096);
        rc_tick_i = 1'b0;
        strobe(1'b1, 1'b0, 1'b0);
        check(!wdt_to_o, "R10 single-clear mode retained", wdt_to_o, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule